// File: doc/BRIEF.md
# Latched Interrupt Controller Register

This block is one 32-bit memory-mapped register. It gathers up to fifteen interrupt lines from peripherals into a single request to a small processor. Each line is sampled on every clock edge. A line seen high latches a pending flag, and the flag stays set until software acknowledges it. Software also holds a per-line enable and a master enable. The request to the processor is raised when the master enable is on and at least one line is both enabled and pending.

Software uses a single word both to read and to write the register. A write always reloads the master enable from the top data bit. That same bit also chooses the direction for the enable field: each enable position written with a one is set when the top bit is one and cleared when it is zero. Enable positions written with zero keep their value. A one written to a pending position acknowledges that line. The acknowledge is refused if the line is still high at that clock edge, so a level source cannot be lost while it is still asserted.

The register layout, with N the number of lines:
- bit 31: master enable
- bits 16+i: enable for line i
- bit 15: current request output, read-only
- bit i: pending for line i

Top module: `irq_latch_reg`

## Requirements
- R1: Every write (wr_en_i high at a rising clock edge) loads the master enable, read back at rd_data_o bit 31, from wr_data_i bit 31.
- R2: On a write, each enable position 16+i for i < NUM_SRC that holds a one becomes wr_data_i bit 31: set when bit 31 is one, cleared when bit 31 is zero. Enable positions written with zero keep their value.
- R3: A pending bit i (rd_data_o bit i) reads one after any rising clock edge at which src_i[i] was high. It stays one until it is acknowledged.
- R4: A write with a one at pending position i clears pending bit i, unless src_i[i] is high at that same edge. In that case the bit stays one.
- R5: rd_data_o bit 15 always equals irq_o.
- R6: irq_o is high exactly when the master enable is one and some line i has both its enable and its pending bit set.
- R7: While rst_n is low (asynchronous, active low), the master enable, all enables and all pending bits are zero, so rd_data_o reads 0 and irq_o reads 0.
- R8: When NUM_SRC is less than 15, the enable and pending positions of the absent lines read zero.
- R9: A write of 0x80000000 changes neither the enables nor the pending bits. It only loads the master enable.
- R10: A write of 0x800F000F turns the master enable on and enables lines 0 to 3. Pending bits 0 to 3 are acknowledged, if not held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt lines, sampled on every clock edge |
| wr_en_i | input | 1 | Write strobe for the register |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Register read value |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench targets these cases:
- An acknowledge while the line is still high. A design that clears anyway drops a live level interrupt.
- A one in an enable position with bit 31 low. A design that treats the field as a plain value, or ignores the direction bit, either sets the enable or wipes its neighbours.
- A write of all zeros in the enable and pending fields. A design that loads the fields outright clears state that software never meant to touch.
- A pending line that is enabled only after it latched. A request output computed from the enables alone, or blind to the master enable, shows up as a wrong irq_o or a wrong bit 15.
- A four-line instance, whose absent positions must stay zero whatever is written.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

  localparam int REG_W      = 32;
  localparam int MAX_SRC    = 15;
  localparam int MASTER_BIT = 31;
  localparam int IRQ_BIT    = 15;
  localparam int EN_LSB     = 16;

  // Next state of one pending flag: a high line wins over an acknowledge.
  function automatic logic pend_next(input logic cur, input logic line, input logic ack);
    return line | (cur & ~ack);
  endfunction

  // Next state of one enable: only a selected position moves, towards dir.
  function automatic logic en_next(input logic cur, input logic sel, input logic dir);
    return sel ? dir : cur;
  endfunction

  // Mask of the positions a configuration of n lines can show.
  function automatic logic [REG_W-1:0] used_mask(input int n);
    logic [REG_W-1:0] m;
    m = '0;
    m[MASTER_BIT] = 1'b1;
    m[IRQ_BIT]    = 1'b1;
    for (int i = 0; i < MAX_SRC; i++) begin
      if (i < n) begin
        m[i]          = 1'b1;
        m[EN_LSB + i] = 1'b1;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_latch_pkg::*;
#(
  parameter int NS = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] line_i,
  input  logic [NS-1:0] ack_i,
  output logic [NS-1:0] pend_o
);

  for (genvar g = 0; g < NS; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o[g] <= 1'b0;
      else        pend_o[g] <= pend_next(pend_o[g], line_i[g], ack_i[g]);
    end
  end

endmodule

// File: rtl/irq_en_bank.sv
module irq_en_bank
  import irq_latch_pkg::*;
#(
  parameter int NS = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic          dir_i,
  input  logic [NS-1:0] sel_i,
  output logic          master_o,
  output logic [NS-1:0] en_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    master_o <= 1'b0;
    else if (wr_i) master_o <= dir_i;
  end

  for (genvar g = 0; g < NS; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_o[g] <= 1'b0;
      else        en_o[g] <= en_next(en_o[g], wr_i & sel_i[g], dir_i);
    end
  end

endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int NS = 15
) (
  input  logic          master_i,
  input  logic [NS-1:0] en_i,
  input  logic [NS-1:0] pend_i,
  output logic          irq_o
);

  logic [NS-1:0] armed;
  assign armed = en_i & pend_i;
  assign irq_o = master_i & (|armed);

endmodule

// File: rtl/irq_latch_reg.sv
module irq_latch_reg
  import irq_latch_pkg::*;
#(
  parameter int NUM_SRC = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic [REG_W-1:0]   wr_data_i,
  output logic [REG_W-1:0]   rd_data_o,
  output logic               irq_o
);

  logic               master;
  logic [NUM_SRC-1:0] en;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] ack;
  logic               unused_wr_bits;

  assign ack            = wr_en_i ? wr_data_i[NUM_SRC-1:0] : '0;
  assign unused_wr_bits = ^wr_data_i;

  irq_pend_bank #(.NS(NUM_SRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (src_i),
    .ack_i  (ack),
    .pend_o (pend)
  );

  irq_en_bank #(.NS(NUM_SRC)) u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (wr_en_i),
    .dir_i    (wr_data_i[MASTER_BIT]),
    .sel_i    (wr_data_i[EN_LSB +: NUM_SRC]),
    .master_o (master),
    .en_o     (en)
  );

  irq_combine #(.NS(NUM_SRC)) u_comb (
    .master_i (master),
    .en_i     (en),
    .pend_i   (pend),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_data_o                       = '0;
    rd_data_o[MASTER_BIT]           = master;
    rd_data_o[EN_LSB +: NUM_SRC]    = en;
    rd_data_o[IRQ_BIT]              = irq_o;
    rd_data_o[NUM_SRC-1:0]          = pend;
  end

endmodule

// File: rtl/irq_latch_chk.sv
module irq_latch_chk
  import irq_latch_pkg::*;
#(
  parameter int NS = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NS-1:0]    src_i,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             irq_o
);

  localparam logic [REG_W-1:0] MASK = used_mask(NS);

  logic [NS-1:0] rd_pend;
  logic [NS-1:0] rd_en;
  logic [NS-1:0] wr_pend;
  logic [NS-1:0] wr_en_f;
  assign rd_pend = rd_data_o[NS-1:0];
  assign rd_en   = rd_data_o[EN_LSB +: NS];
  assign wr_pend = wr_data_i[NS-1:0];
  assign wr_en_f = wr_data_i[EN_LSB +: NS];

  AST_MASTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> rd_data_o[MASTER_BIT] == $past(wr_data_i[MASTER_BIT])); // R1

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i[MASTER_BIT]) |=> ((rd_en & $past(wr_en_f)) == $past(wr_en_f))); // R2

  AST_EN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_data_i[MASTER_BIT]) |=> ((rd_en & $past(wr_en_f)) == '0)); // R2

  AST_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i || wr_en_f == '0) |=> $stable(rd_en)); // R9

  AST_PEND_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_i) |=> ((rd_pend & $past(src_i)) == $past(src_i))); // R3

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> ((rd_pend & $past(wr_pend & ~src_i)) == '0)); // R4

  AST_IRQ_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[IRQ_BIT] == irq_o); // R5

  AST_IRQ_COMBINE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (rd_data_o[MASTER_BIT] && ((rd_en & rd_pend) != '0))); // R6

  if (NS < MAX_SRC) begin : g_rsvd
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_o & ~MASK) == '0); // R8
  end

endmodule

bind irq_latch_reg irq_latch_chk #(.NS(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_i     (src_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o)
);

// File: tb/sim_irq_latch_reg.sv
`timescale 1ns/1ps
module sim_irq_latch_reg;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [14:0] src;
  logic        wr;
  logic [31:0] d;
  logic [31:0] rd0, rd1;
  logic        irq0, irq1;

  always #2.5 clk = ~clk;

  irq_latch_reg #(.NUM_SRC(15)) u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr),
    .wr_data_i(d), .rd_data_o(rd0), .irq_o(irq0));

  irq_latch_reg #(.NUM_SRC(4)) u1 (
    .clk(clk), .rst_n(rst_n), .src_i(src[3:0]), .wr_en_i(wr),
    .wr_data_i(d), .rd_data_o(rd1), .irq_o(irq1));

  // Reference state, kept from the requirements.
  logic        m_mst;
  logic [14:0] m_en;
  logic [14:0] m_pd;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 0;
  logic [31:0] rng   = 32'h1234_5678;

  function automatic logic [31:0] expect_word(input logic mst, input logic [14:0] en,
                                              input logic [14:0] pd, input int n);
    logic [14:0] keep, e, p;
    keep = 15'((32'd1 << n) - 1);
    e = en & keep;
    p = pd & keep;
    return {mst, e, (mst && ((e & p) != 0)), p};
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // Drive at a falling edge, update the reference at the rising edge,
  // compare at the following falling edge.
  task automatic step(input logic [14:0] s, input logic w, input logic [31:0] dd, input string tag);
    src = s; wr = w; d = dd;
    @(posedge clk);
    if (w) begin
      m_mst = dd[31];
      for (int i = 0; i < 15; i++) if (dd[16+i]) m_en[i] = dd[31];
    end
    m_pd = s | (m_pd & ~(w ? dd[14:0] : 15'h0));
    @(negedge clk);
    cmp({tag, " word"}, rd0, expect_word(m_mst, m_en, m_pd, 15));
    cmp("R5 irq_o vs bit 15", {31'b0, irq0}, {31'b0, expect_word(m_mst, m_en, m_pd, 15)[15]});
    cmp({"R8 four-line ", tag}, rd1, expect_word(m_mst, m_en, m_pd, 4));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src = '0; wr = 1'b0; d = '0;
    m_mst = 1'b0; m_en = '0; m_pd = '0;
    repeat (3) @(negedge clk);
    src = 15'h7fff; wr = 1'b1; d = 32'hffff_ffff;   // ignored while in reset
    @(negedge clk);
    cmp("R7 reset word", rd0, 32'h0);
    cmp("R7 reset irq", {31'b0, irq0}, 32'h0);
    src = '0; wr = 1'b0; d = '0;
    @(negedge clk);
    rst_n = 1'b1;

    // R10 example sequence, then R9 leaves fields alone
    step(15'h0000, 1'b1, 32'h800F_000F, "R10 master and lines 0-3 on");
    step(15'h0000, 1'b1, 32'h8000_0000, "R9 master-only write");
    // R3 latch and hold
    step(15'h0004, 1'b0, 32'h0, "R3 line 2 latches");
    step(15'h0000, 1'b0, 32'h0, "R3 line 2 holds");
    step(15'h0000, 1'b1, 32'h8000_0000, "R9 pending untouched");
    // R4 blocked then accepted
    step(15'h0004, 1'b1, 32'h8000_0004, "R4 ack refused while high");
    step(15'h0000, 1'b1, 32'h8000_0004, "R4 ack accepted after drop");
    // R2 clear direction, master off
    step(15'h0000, 1'b1, 32'h0002_0000, "R2 clear enable 1");
    step(15'h0000, 1'b1, 32'h8000_0000, "R1 master back on");
    // R6 pending but not enabled, then enabled later
    step(15'h0020, 1'b0, 32'h0, "R6 pending line 5 disabled");
    step(15'h0000, 1'b1, 32'h8020_0000, "R6 late enable raises irq");
    step(15'h0000, 1'b1, 32'h0000_0000, "R1 master off masks irq");
    step(15'h0000, 1'b1, 32'h8000_0000, "R1 master on again");
    // R2 zero bits keep their enables
    step(15'h4000, 1'b1, 32'hC000_0000, "R2 enable line 14 only");
    step(15'h0000, 1'b1, 32'h8000_4000, "R4 ack line 14");

    // Asynchronous reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    cmp("R7 async reset word", rd0, 32'h0);
    m_mst = 1'b0; m_en = '0; m_pd = '0;
    @(negedge clk);
    rst_n = 1'b1;

    // Per-line sweep: enable, latch, blocked ack, ack, disable
    for (int i = 0; i < 15; i++) begin
      step(15'h0, 1'b1, 32'h8000_0000 | (32'd1 << (16 + i)), "R2 sweep enable");
      step(15'(1 << i), 1'b0, 32'h0, "R3 sweep latch");
      step(15'(1 << i), 1'b1, 32'h8000_0000 | (32'd1 << i), "R4 sweep refused");
      step(15'h0, 1'b1, 32'h8000_0000 | (32'd1 << i), "R4 sweep cleared");
      step(15'h0, 1'b1, 32'h0000_0000 | (32'd1 << (16 + i)), "R2 sweep disable");
    end

    // Mixed traffic
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] a, b, c;
      rng = next_rng(rng); a = rng;
      rng = next_rng(rng); b = rng;
      rng = next_rng(rng); c = rng;
      step(a[14:0] & b[14:0], b[31] | b[30], c, "R1 R2 R3 R4 R6 traffic");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule